// File: doc/BRIEF.md
# Slope-Corrected Polyphase Arbitrary Resampler

This block changes the sample rate of a complex baseband stream by any ratio, including ratios that are not integers. It holds one tapped delay line. Two coefficient banks read that line: a polyphase lowpass bank and the matching polyphase derivative bank. A phase accumulator keeps a sub-filter index in its integer bits and a fine position in its fractional bits. Each output is the lowpass sub-filter result plus the fractional position times the derivative sub-filter result. This corrects the local slope between neighbouring phases, so the output is an interpolation and not just the nearest phase.

For every output, the accumulator advances by a nominal unsigned step plus a signed timing correction. The correction would normally come from a timing loop outside this block. Every wrap of the accumulator past the phase count means that one more input sample must enter the delay line before the next output is formed. The input side applies backpressure with a ready signal while those samples are outstanding. A step below one sample gives upsampling, with back-to-back outputs. A step of several samples gives decimation.

The coefficient banks are computed from a piecewise-linear prototype, so with the default parameters the output is an exact linear interpolation between two adjacent delay-line taps.

Top module: `slope_resampler`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and the delay line is all zero. The first output is produced only after TAPS (20) input samples have been accepted.
- R2: An input sample is accepted on a rising edge where in_valid and in_ready are both high. No output is produced on an edge that accepts a sample. in_ready falls only after an accepted sample.
- R3: The phase accumulator is 20 bits: 4 integer bits select one of 16 phases and 16 fractional bits give the fine position. step is unsigned Q5.16. corr is two's-complement Q5.16. The effective step is step+corr, forced to zero when negative, and is taken from the inputs on the edge that produces an output. The accumulator changes only on such an edge.
- R4: After each output, the block must accept floor((acc+effective step)/2^20) new samples before the next output. The accumulator keeps (acc+effective step) mod 2^20. in_ready is high exactly while samples are still owed. When none are owed, the next output follows on the next edge.
- R5: The lowpass prototype has 320 entries, h[n] = 2048*max(0, 16-|n-160|). Phase p, tap k uses h[16k+p]. The derivative bank uses h[16k+p+1]-h[16k+p], with h = 0 outside 0..319. Tap 0 is the newest sample.
- R6: For each rail, y = (lowpass*2^16 + frac*derivative) rounded half up at bit 31 (arithmetic) and limited to the 16-bit signed range. With the R5 banks this equals floor((t10*(2^20-A) + t9*A + 2^19)/2^20), where A is the accumulator and t9, t10 are delay taps 9 and 10.
- R7: The real and imaginary rails share one delay-line position and one phase, and are computed alike.
- R8: out_valid is a one-cycle pulse per output, registered together with out_re/out_im on the edge where no samples are owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block is owed samples and takes one this cycle |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| step | input | 21 | Nominal phase step, unsigned Q5.16 |
| corr | input | 21 | Timing correction, signed Q5.16 |
| out_valid | output | 1 | Output sample pulse |
| out_re | output | 16 | Interpolated real part, signed |
| out_im | output | 16 | Interpolated imaginary part, signed |

## Verification
A wrong phase value does not stay hidden. It changes the interpolation weight of the very next output, and it shifts the count of owed samples, which shows at in_ready within the same output interval. Because the bench replays the accumulator and the debt counter every cycle and compares both in_ready and each output value, an error in carry, clamping or delay-line order shows at the first output or the first ready edge after it occurs. The step sweep covers downsampling, unit-rate, upsampling, a negative correction clamped to zero and the largest step plus correction, so every carry count from zero to three is reached.

// File: rtl/slope_resampler.sv
module slope_resampler #(
  parameter int PHASES = 16,
  parameter int TAPS   = 20,
  parameter int DW     = 16,
  parameter int FB     = 16,
  parameter int SB     = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic        [SB-1:0] step,
  input  logic signed [SB-1:0] corr,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int PB   = $clog2(PHASES);
  localparam int AW   = PB + FB;
  localparam int NB   = $clog2(TAPS + 1);
  localparam int CW   = 18;
  localparam int CSH  = 15;
  localparam int UNIT = (1 << CSH) / PHASES;
  localparam int PLEN = PHASES * TAPS;
  localparam int CTR  = PLEN / 2;
  localparam int RS   = CSH + FB;
  localparam longint YMAX = (longint'(1) <<< (DW - 1)) - 1;
  localparam longint YMIN = -(longint'(1) <<< (DW - 1));

  logic signed [DW-1:0] line_re [TAPS];
  logic signed [DW-1:0] line_im [TAPS];
  logic [AW-1:0] mu;
  logic [NB-1:0] need;
  logic [PB-1:0] ph;
  logic signed [DW-1:0] y_re, y_im;
  logic [AW-1:0] mu_nxt;
  logic [NB-1:0] carries;

  function automatic logic signed [CW-1:0] proto(input int n);
    int d;
    d = n - CTR;
    if (d < 0) d = -d;
    if (n < 0 || n >= PLEN || d >= PHASES) return '0;
    return CW'((PHASES - d) * UNIT);
  endfunction

  function automatic logic signed [DW-1:0] round_sat(input longint v);
    longint r;
    r = (v + (longint'(1) <<< (RS - 1))) >>> RS;
    if (r > YMAX) r = YMAX;
    if (r < YMIN) r = YMIN;
    return DW'(r);
  endfunction

  assign ph       = mu[AW-1:FB];
  assign in_ready = (need != '0);

  always_comb begin
    longint lp_r, lp_i, dv_r, dv_i, fr, eff, sum;
    int n;
    lp_r = 0; lp_i = 0; dv_r = 0; dv_i = 0;
    for (int k = 0; k < TAPS; k++) begin
      n = k * PHASES + int'(ph);
      lp_r = lp_r + longint'(proto(n)) * longint'(line_re[k]);
      lp_i = lp_i + longint'(proto(n)) * longint'(line_im[k]);
      dv_r = dv_r + longint'(proto(n + 1) - proto(n)) * longint'(line_re[k]);
      dv_i = dv_i + longint'(proto(n + 1) - proto(n)) * longint'(line_im[k]);
    end
    fr   = longint'(mu[FB-1:0]);
    y_re = round_sat((lp_r <<< FB) + fr * dv_r);
    y_im = round_sat((lp_i <<< FB) + fr * dv_i);
    eff  = longint'(step) + longint'(corr);
    if (eff < 0) eff = 0;
    sum     = longint'(mu) + eff;
    carries = NB'(sum >>> AW);
    mu_nxt  = AW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mu        <= '0;
      need      <= NB'(TAPS);
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      for (int k = 0; k < TAPS; k++) begin
        line_re[k] <= '0;
        line_im[k] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      if (need == '0) begin
        out_valid <= 1'b1;
        out_re    <= y_re;
        out_im    <= y_im;
        mu        <= mu_nxt;
        need      <= carries;
      end else if (in_valid) begin
        line_re[0] <= in_re;
        line_im[0] <= in_im;
        for (int k = TAPS - 1; k > 0; k--) begin
          line_re[k] <= line_re[k-1];
          line_im[k] <= line_im[k-1];
        end
        need <= need - 1'b1;
      end
    end
  end

  // R2
  accept_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);

  // R2
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(mu));

  // R4
  need_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    need <= NB'(TAPS));
endmodule

// File: tb/slope_resampler_tb.sv
module slope_resampler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ONE = 1 << 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic [20:0] step = '0;
  logic signed [20:0] corr = '0;
  logic out_valid;
  logic signed [15:0] out_re, out_im;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slope_resampler dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .step(step), .corr(corr),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic longint s_re(input int i);
    return longint'((i * 7919 + 1234) % 65536) - 32768;
  endfunction

  function automatic longint s_im(input int i);
    if (i % 3 == 0) return 32767;
    if (i % 3 == 1) return -32768;
    return longint'((i * 97) % 2000) - 1000;
  endfunction

  function automatic longint interp(input longint a, input longint b, input longint p);
    return (a * (ONE - p) + b * p + (ONE / 2)) >>> 20;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  int     seg_step [8] = '{2507407, 1048576, 557056, 2507407, 1310720, 327680, 2097151, 19661};
  int     seg_corr [8] = '{0, 0, 0, 98304, -49152, -655360, 1048575, 0};
  int     seg_outs [8] = '{150, 60, 60, 60, 60, 20, 60, 80};
  bit     seg_rnd  [8] = '{1, 0, 0, 1, 1, 0, 0, 1};

  initial begin
    longint m_mu, eff, sum;
    int m_need, idx, outs, seg, seg_cnt, cyc;
    logic [7:0] lfsr;
    m_mu = 0; m_need = 20; idx = 0; outs = 0; seg = 0; seg_cnt = 0; cyc = 0;
    lfsr = 8'h5a;
    step = 21'(seg_step[0]);
    corr = 21'(seg_corr[0]);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid in reset", longint'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 in_ready after reset", longint'(in_ready), 1);
    in_re = 16'(s_re(0));
    in_im = 16'(s_im(0));
    in_valid = 1'b1;
    while (seg < 8) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        check("watchdog", 0, 1);
        break;
      end
      if (m_need == 0) begin
        // R8 output pulse
        check("R8 out_valid", longint'(out_valid), 1);
        // R3 R5 R6 real rail value
        check("R3 R5 R6 out_re", longint'(out_re), interp(s_re(idx - 11), s_re(idx - 10), m_mu));
        // R7 imaginary rail value
        check("R7 out_im", longint'(out_im), interp(s_im(idx - 11), s_im(idx - 10), m_mu));
        eff = longint'(step) + longint'(corr);
        if (eff < 0) eff = 0;
        sum = m_mu + eff;
        m_need = int'(sum >>> 20);
        m_mu = sum % ONE;
        outs++;
        seg_cnt++;
      end else begin
        // R2 no output while samples owed
        check("R2 out_valid low", longint'(out_valid), 0);
        if (in_valid) begin
          idx++;
          m_need--;
        end
      end
      // R4 ready tracks owed samples
      check("R4 in_ready", longint'(in_ready), longint'(m_need != 0));
      if (seg_cnt >= seg_outs[seg]) begin
        seg++;
        seg_cnt = 0;
      end
      if (seg < 8) begin
        step = 21'(seg_step[seg]);
        corr = 21'(seg_corr[seg]);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        in_valid = seg_rnd[seg] ? (lfsr[0] | lfsr[1]) : 1'b1;
        in_re = 16'(s_re(idx));
        in_im = 16'(s_im(idx));
      end
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule